// File: doc/BRIEF.md
# High-Speed UART Receive Path

This block is the receive half of a fixed-format serial port. It resynchronises an asynchronous line, counts oversample ticks produced by a programmable divider, and assembles frames of one start bit, eight data bits sent least-significant bit first, and one stop bit. There is no parity. Every completed frame is written into a 64-entry queue together with a framing-error tag and a break tag.

Software, or an interrupt handler, drains the queue through a single read strobe. The read word is valid combinationally while the strobe is high, and each strobe with data present removes one entry. When the queue has nothing in it, the read word carries an "empty" tag, so a reader can keep fetching until it sees that tag. A level output packs the receive fill count together with a fill count supplied by the transmitter. A one-cycle overrun pulse tells the interrupt logic that a frame was lost because the queue was full.

Two configuration values are loaded through a write strobe. The divider value sets the bit period. The sample offset selects the oversample tick on which each bit is captured.

Top module: `hsu_rx_path`

## Requirements
- R1: After reset the RX count in `level_o[7:0]` is 0, `ovr_o` is low, and `rd_data_o` reads 0x100, meaning only the empty tag in bit 8 is set.
- R2: After reset the divider value is 255, so a bit lasts 3584 clocks, and the sample offset is 20. A frame sent at that period with no configuration write is received correctly.
- R3: After a configuration write with divider value N, a bit lasts (N+1)×14 clocks. Frames sent at N = 0, 1 and 3 are received correctly, with the first data bit on the line landing in bit 0.
- R4: The read word carries the data in bits 7:0, the empty tag in bit 8, the framing-error tag in bit 9 and the break tag in bit 10. Each read strobe taken while the queue holds data removes exactly one entry. A strobe taken on an empty queue changes nothing.
- R5: A frame whose stop bit is sampled low and whose data is not all zero is stored with bit 9 set and bit 10 clear.
- R6: A frame whose eight data bits and stop bit are all sampled low is stored as data 0x00 with bit 10 set and bit 9 clear. No further frame is stored until the line has returned high.
- R7: A low pulse on the line that has ended before the start-bit sample point is rejected, and nothing is stored.
- R8: The start bit is captured at tick (offset − 14) of the bit, and each later bit is captured one bit time after the previous one. Offsets are clamped to the range 14..27, so an offset of 3 behaves like 14. With offset 14 and N = 1, an 8-clock low pulse is taken as a start bit and stores 0xFF.
- R9: The queue holds 64 entries in arrival order. A frame that completes while the queue is full and no read is taking place is dropped, and `ovr_o` goes high for exactly one cycle.
- R10: `level_o[15:8]` always equals `tx_level_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| cfg_wr_i | input | 1 | Strobe that loads the divider and offset |
| cfg_rate_i | input | 8 | Divider value N; bit period is (N+1)×14 clocks |
| cfg_offset_i | input | 5 | Sample offset in oversample ticks |
| rd_i | input | 1 | Read strobe; pops one entry when data is present |
| rd_data_o | output | 11 | Read word: {break, frame error, empty, data} |
| tx_level_i | input | 8 | Fill count supplied by the transmitter |
| level_o | output | 16 | {TX count, RX count} |
| ovr_o | output | 1 | One-cycle pulse when a frame is dropped |

## Verification
The hardest condition to reach from the ports is an overrun. It needs 64 unread frames waiting, and then a 65th frame completing while no read strobe is active. The stimulus sets the fastest divider and streams 65 back-to-back frames with the read strobe held low. It counts the overrun pulses, then drains the queue and checks the order of the entries. The sample-offset clamp is reached indirectly: a short low pulse is stored or rejected depending only on where the start-bit sample falls.

// File: rtl/hsu_rx_pkg.sv
package hsu_rx_pkg;
    localparam int OSR     = 14;
    localparam int DATA_W  = 8;
    localparam int OFS_W   = 5;
    localparam int PH_W    = 4;
    localparam int BIDX_W  = 4;
    localparam int STOP_IX = DATA_W + 1;

    // One queue/read word: {break, frame error, empty, data}
    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              empty;
        logic [DATA_W-1:0] data;
    } rx_word_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_HOLD_LOW
    } rx_state_t;

    // The offset counts ticks from the start edge to the first data sample;
    // the phase within a bit is therefore offset - OSR, clamped to one bit.
    function automatic logic [PH_W-1:0] sample_phase(input logic [OFS_W-1:0] ofs);
        if (int'(ofs) < OSR)
            return '0;
        else if (int'(ofs) > 2 * OSR - 1)
            return PH_W'(OSR - 1);
        else
            return PH_W'(int'(ofs) - OSR);
    endfunction
endpackage

// File: rtl/hsu_rx_baud.sv
module hsu_rx_baud #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              restart_i,
    output logic              tick_o
);
    logic [RATE_W-1:0] cnt;

    assign tick_o = (cnt == rate_i) && !restart_i;

    always_ff @(posedge clk) begin
        if (rst || restart_i)
            cnt <= '0;
        else if (cnt == rate_i)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/hsu_rx_frame.sv
module hsu_rx_frame
    import hsu_rx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            rxd_i,
    input  logic            tick_i,
    input  logic [PH_W-1:0] samp_ph_i,
    output logic            restart_o,
    output logic            char_vld_o,
    output rx_word_t        char_o
);
    logic              rx_s1, rx_s2, rx_prev;
    logic              fall;
    rx_state_t         state;
    logic [PH_W-1:0]   ph;
    logic [BIDX_W-1:0] bidx;
    logic [DATA_W-1:0] sh;
    logic              at_sample;

    assign fall      = rx_prev && !rx_s2;
    assign restart_o = (state == ST_IDLE) && fall;
    assign at_sample = tick_i && (ph == samp_ph_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_s1   <= 1'b1;
            rx_s2   <= 1'b1;
            rx_prev <= 1'b1;
        end else begin
            rx_s1   <= rxd_i;
            rx_s2   <= rx_s1;
            rx_prev <= rx_s2;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            ph         <= '0;
            bidx       <= '0;
            sh         <= '0;
            char_vld_o <= 1'b0;
            char_o     <= '0;
        end else begin
            char_vld_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (fall) begin
                        state <= ST_ACTIVE;
                        ph    <= '0;
                        bidx  <= '0;
                    end
                end
                ST_ACTIVE: begin
                    if (at_sample) begin
                        if (bidx == '0) begin
                            if (rx_s2)
                                state <= ST_IDLE;
                        end else if (int'(bidx) < STOP_IX) begin
                            sh <= {rx_s2, sh[DATA_W-1:1]};
                        end else begin
                            char_vld_o   <= 1'b1;
                            char_o.data  <= sh;
                            char_o.empty <= 1'b0;
                            char_o.ferr  <= !rx_s2 && (sh != '0);
                            char_o.brk   <= !rx_s2 && (sh == '0);
                            state        <= (!rx_s2 && (sh == '0)) ? ST_HOLD_LOW : ST_IDLE;
                        end
                    end
                    if (tick_i) begin
                        if (int'(ph) == OSR - 1) begin
                            ph   <= '0;
                            bidx <= bidx + 1'b1;
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                end
                ST_HOLD_LOW: begin
                    if (rx_s2)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hsu_rx_fifo.sv
module hsu_rx_fifo
    import hsu_rx_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  rx_word_t      push_word_i,
    input  logic          pop_req_i,
    output rx_word_t      head_o,
    output logic [CW-1:0] count_o,
    output logic          ovr_o
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    rx_word_t        mem [DEPTH];
    logic [AW-1:0]   wp, rp;
    logic            pop, push_ok, full;

    assign full    = (int'(count_o) == DEPTH);
    assign pop     = pop_req_i && (count_o != '0);
    assign push_ok = push_i && (!full || pop);

    always_comb begin
        if (count_o == '0) begin
            head_o       = '0;
            head_o.empty = 1'b1;
        end else begin
            head_o = mem[rp];
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wp] <= push_word_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp      <= '0;
            rp      <= '0;
            count_o <= '0;
            ovr_o   <= 1'b0;
        end else begin
            ovr_o <= push_i && !push_ok;
            if (push_ok)
                wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (pop)
                rp <= (rp == LAST) ? '0 : rp + 1'b1;
            case ({push_ok, pop})
                2'b10:   count_o <= count_o + 1'b1;
                2'b01:   count_o <= count_o - 1'b1;
                default: count_o <= count_o;
            endcase
        end
    end
endmodule

// File: rtl/hsu_rx_path.sv
module hsu_rx_path
    import hsu_rx_pkg::*;
#(
    parameter int              DEPTH    = 64,
    parameter int              RATE_W   = 8,
    parameter int              LVL_W    = 8,
    parameter logic [RATE_W-1:0] RATE_RST = '1,
    parameter logic [OFS_W-1:0]  OFS_RST  = 5'd20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rxd_i,
    input  logic                cfg_wr_i,
    input  logic [RATE_W-1:0]   cfg_rate_i,
    input  logic [OFS_W-1:0]    cfg_offset_i,
    input  logic                rd_i,
    output logic [10:0]         rd_data_o,
    input  logic [LVL_W-1:0]    tx_level_i,
    output logic [2*LVL_W-1:0]  level_o,
    output logic                ovr_o
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [RATE_W-1:0] rate_q;
    logic [OFS_W-1:0]  ofs_q;
    logic              tick, restart, char_vld;
    rx_word_t          char_w, head;
    logic [CW-1:0]     rx_count;

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= RATE_RST;
            ofs_q  <= OFS_RST;
        end else if (cfg_wr_i) begin
            rate_q <= cfg_rate_i;
            ofs_q  <= cfg_offset_i;
        end
    end

    hsu_rx_baud #(.RATE_W(RATE_W)) u_baud (
        .clk       (clk),
        .rst       (rst),
        .rate_i    (rate_q),
        .restart_i (restart),
        .tick_o    (tick)
    );

    hsu_rx_frame u_frame (
        .clk        (clk),
        .rst        (rst),
        .rxd_i      (rxd_i),
        .tick_i     (tick),
        .samp_ph_i  (sample_phase(ofs_q)),
        .restart_o  (restart),
        .char_vld_o (char_vld),
        .char_o     (char_w)
    );

    hsu_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk         (clk),
        .rst         (rst),
        .push_i      (char_vld),
        .push_word_i (char_w),
        .pop_req_i   (rd_i),
        .head_o      (head),
        .count_o     (rx_count),
        .ovr_o       (ovr_o)
    );

    assign rd_data_o = head;
    assign level_o   = {tx_level_i, LVL_W'(rx_count)};
endmodule

// File: rtl/hsu_rx_checker.sv
module hsu_rx_checker (
    input logic        clk,
    input logic        rst,
    input logic        rd_i,
    input logic [10:0] rd_data_o,
    input logic [15:0] level_o,
    input logic        ovr_o
);
    logic [7:0] cnt;
    assign cnt = level_o[7:0];

    // R9: a drop is only reported when the queue was full
    p_ovr_when_full_r9: assert property (@(posedge clk) disable iff (rst)
        ovr_o |-> ($past(cnt) == 8'd64));

    // R9: overrun is a single-cycle pulse
    p_ovr_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        ovr_o |=> !ovr_o);

    // R9: fill never exceeds the depth
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        cnt <= 8'd64);

    // R4: fill moves by at most one entry per cycle
    p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt != $past(cnt)) |-> ((cnt == $past(cnt) + 8'd1) || (cnt + 8'd1 == $past(cnt))));

    // R4: empty tag agrees with the fill count
    p_empty_tag_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt == 8'd0) == rd_data_o[8]);

    // R4: a read of a non-empty queue with nothing arriving lowers the count
    p_pop_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_i && cnt != 8'd0 && !$rose(cnt)) |=> (cnt <= $past(cnt)));

    // R6: break and framing tags are never both set
    p_brk_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(rd_data_o[10] && rd_data_o[9]));
endmodule

bind hsu_rx_path hsu_rx_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_i      (rd_i),
    .rd_data_o (rd_data_o),
    .level_o   (level_o),
    .ovr_o     (ovr_o)
);

// File: tb/sim_hsu_rx_path.sv
module sim_hsu_rx_path;
    localparam int CLK_P = 10;
    localparam int WDOG  = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rxd = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_rate = 8'd0;
    logic [4:0]  cfg_ofs = 5'd20;
    logic        rd = 1'b0;
    logic [10:0] rd_data;
    logic [7:0]  tx_lvl = 8'd0;
    logic [15:0] level;
    logic        ovr;

    int checks = 0;
    int errors = 0;
    int cur_rate = 255;
    int ovr_seen = 0;
    int cyc = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    hsu_rx_path u0 (
        .clk          (clk),
        .rst          (rst),
        .rxd_i        (rxd),
        .cfg_wr_i     (cfg_wr),
        .cfg_rate_i   (cfg_rate),
        .cfg_offset_i (cfg_ofs),
        .rd_i         (rd),
        .rd_data_o    (rd_data),
        .tx_level_i   (tx_lvl),
        .level_o      (level),
        .ovr_o        (ovr)
    );

    always @(negedge clk) if (!rst && ovr) ovr_seen++;

    always @(posedge clk) begin
        cyc++;
        if (cyc == WDOG && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input int rate, input int ofs);
        @(negedge clk);
        cfg_rate = 8'(rate);
        cfg_ofs  = 5'(ofs);
        cfg_wr   = 1'b1;
        @(negedge clk);
        cfg_wr   = 1'b0;
        cur_rate = rate;
    endtask

    task automatic send_byte(input logic [7:0] d, input logic stop);
        int bt;
        bt = (cur_rate + 1) * 14;
        @(negedge clk);
        rxd = 1'b0;
        repeat (bt) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (bt) @(negedge clk);
        end
        rxd = stop;
        repeat (bt) @(negedge clk);
        rxd = 1'b1;
        repeat (bt) @(negedge clk);
    endtask

    task automatic read_word(output logic [10:0] w);
        @(negedge clk);
        w  = rd_data;
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        check("R1 level", int'(level[7:0]), 0);
        check("R1 read word", int'(rd_data), 'h100);
        check("R1 overrun", int'(ovr), 0);
    endtask

    task automatic t_default_rate;
        logic [10:0] w;
        send_byte(8'hA5, 1'b1);
        check("R2 level", int'(level[7:0]), 1);
        read_word(w);
        check("R2 data at 3584 clk/bit", int'(w), 'h0A5);
    endtask

    task automatic t_rates;
        logic [10:0] w;
        write_cfg(0, 20);
        send_byte(8'h81, 1'b1);
        write_cfg(1, 20);
        send_byte(8'h3C, 1'b1);
        write_cfg(3, 20);
        send_byte(8'hF0, 1'b1);
        check("R3 level", int'(level[7:0]), 3);
        read_word(w); check("R3 rate 0", int'(w), 'h081);
        read_word(w); check("R3 rate 1", int'(w), 'h03C);
        read_word(w); check("R3 rate 3", int'(w), 'h0F0);
        read_word(w); check("R4 empty word", int'(w), 'h100);
        check("R4 empty read no pop", int'(level[7:0]), 0);
    endtask

    task automatic t_framing;
        logic [10:0] w;
        write_cfg(1, 20);
        send_byte(8'h5A, 1'b0);
        send_byte(8'h33, 1'b1);
        check("R5 level", int'(level[7:0]), 2);
        read_word(w); check("R5 frame error tag", int'(w), 'h25A);
        read_word(w); check("R5 clean after error", int'(w), 'h033);
    endtask

    task automatic t_break;
        logic [10:0] w;
        @(negedge clk);
        rxd = 1'b0;
        repeat (28 * 16) @(negedge clk);
        check("R6 single entry while low", int'(level[7:0]), 1);
        rxd = 1'b1;
        repeat (28 * 2) @(negedge clk);
        check("R6 level", int'(level[7:0]), 1);
        read_word(w); check("R6 break tag", int'(w), 'h400);
        send_byte(8'h66, 1'b1);
        read_word(w); check("R6 after line high", int'(w), 'h066);
    endtask

    task automatic glitch;
        @(negedge clk);
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (28 * 12) @(negedge clk);
    endtask

    task automatic t_glitch_offset;
        logic [10:0] w;
        write_cfg(1, 20);
        glitch();
        check("R7 glitch rejected", int'(level[7:0]), 0);
        write_cfg(1, 14);
        glitch();
        check("R8 offset 14 level", int'(level[7:0]), 1);
        read_word(w); check("R8 offset 14 word", int'(w), 'h0FF);
        write_cfg(1, 3);
        glitch();
        read_word(w); check("R8 clamp offset 3", int'(w), 'h0FF);
        write_cfg(1, 20);
        send_byte(8'h96, 1'b1);
        read_word(w); check("R8 offset 20 frame", int'(w), 'h096);
    endtask

    task automatic t_overrun;
        logic [10:0] w;
        int bad;
        write_cfg(0, 20);
        ovr_seen = 0;
        for (int i = 0; i < 65; i++) send_byte(8'(i ^ 'h3C), 1'b1);
        check("R9 full level", int'(level[7:0]), 64);
        check("R9 overrun pulses", ovr_seen, 1);
        bad = 0;
        for (int i = 0; i < 64; i++) begin
            read_word(w);
            if (w != 11'(i ^ 'h3C)) bad++;
        end
        check("R9 order mismatches", bad, 0);
        read_word(w); check("R9 dropped frame absent", int'(w), 'h100);
    endtask

    task automatic t_tx_level;
        @(negedge clk);
        tx_lvl = 8'h2A;
        @(negedge clk);
        check("R10 tx level", int'(level[15:8]), 'h2A);
        tx_lvl = 8'hC1;
        @(negedge clk);
        check("R10 tx level 2", int'(level[15:8]), 'hC1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_default_rate();
        t_rates();
        t_framing();
        t_break();
        t_glitch_offset();
        t_overrun();
        t_tx_level();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule